// File: doc/BRIEF.md
# Four-Lane Field Scatter and Gather Unit

This unit converts between one packed 32-bit word and four separate 32-bit elements. A scatter splits a source word into four fields of equal width, from 1 to 8 bits, and places each field in the low bits of its own output with all higher bits cleared. A typical use is splitting a packed pixel into its colour channels. A gather reduces four input elements to one 32-bit result, either by summing them or by multiplying them. Because addition equals bitwise OR when the operands share no set bits, a gather-sum of fields that do not overlap also packs channels back into one word.

Each transaction is taken in through a valid/ready pair and returned through a second valid/ready pair. The unit handles one transaction at a time. A result stays on the outputs until the consumer accepts it. Scatter and sum results appear one cycle after acceptance. The product passes through a two-level multiplier tree and appears two cycles after acceptance.

Top module: `fieldScatterGather`

## Requirements
- R1: While and after reset, outValid is 0, inReady is 1 and all four result outputs are zero.
- R2: For a scatter (opSel = 2'b00) the field width is w = fieldCode + 1. Result lane i (i = 0..3) equals (srcWord >> (i*w)) & (2^w - 1).
- R3: A scatter with fieldCode = 3'd7 returns srcWord bits [7:0] on res0, [15:8] on res1, [23:16] on res2 and [31:24] on res3, each zero-extended.
- R4: After a scatter or gather-sum is accepted (inValid and inReady high at a rising edge), outValid is high from the next cycle.
- R5: A gather-sum (opSel = 2'b01) puts (elem0 + elem1 + elem2 + elem3) mod 2^32 on res0. Every gather drives res1, res2 and res3 to zero.
- R6: A gather-product (opSel = 2'b10) puts (elem0 * elem1 * elem2 * elem3) mod 2^32 on res0. outValid stays low in the cycle after acceptance and is high in the cycle after that.
- R7: opSel = 2'b11 gives the same result and timing as a gather-sum.
- R8: While outValid is high and outReady is low, outValid stays high, the results do not change and inReady is low. A cycle with outReady high returns the unit to idle, with inReady high and outValid low.
- R9: Input values and inValid pulses that arrive while inReady is low have no effect on the results that are presented.
- R10: A scatter ignores elem0..elem3. A gather ignores srcWord and fieldCode.
- R11: A gather-sum of elements whose set bits do not overlap equals their bitwise OR, which packs separate channels into one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A request is offered |
| inReady | output | 1 | The unit is idle and can take a request |
| opSel | input | 2 | 00 scatter, 01 gather-sum, 10 gather-product, 11 gather-sum |
| fieldCode | input | 3 | Scatter field width minus one |
| srcWord | input | 32 | Packed source word for a scatter |
| elem0 | input | 32 | Gather element 0 |
| elem1 | input | 32 | Gather element 1 |
| elem2 | input | 32 | Gather element 2 |
| elem3 | input | 32 | Gather element 3 |
| outValid | output | 1 | A result is presented |
| outReady | input | 1 | The consumer takes the result |
| res0 | output | 32 | Scatter lane 0, or the gather result |
| res1 | output | 32 | Scatter lane 1, zero for a gather |
| res2 | output | 32 | Scatter lane 2, zero for a gather |
| res3 | output | 32 | Scatter lane 3, zero for a gather |

## Verification
The hardest case to reach is a stalled output under load: a result held back by the consumer while new requests and changed operands are offered against a low inReady. The stimulus holds outReady low for a random number of cycles after each result. During those cycles it keeps inValid high and drives fresh random operands, then checks that the result and the handshake have not moved. The product path needs carries across the 32-bit truncation, so the directed cases include all-ones operands and factors whose product is a multiple of 2^32.

// File: rtl/sgPkg.sv
package sgPkg;
  localparam int SG_DATA_W  = 32;
  localparam int SG_LANES   = 4;
  localparam int SG_FCODE_W = 3;
  localparam int SG_FW_W    = SG_FCODE_W + 1;
  localparam int SG_SH_W    = $clog2(SG_DATA_W) + 1;
  localparam int SG_MAXFW   = 1 << SG_FCODE_W;

  typedef enum logic [1:0] {
    OP_SCATTER = 2'b00,
    OP_GSUM    = 2'b01,
    OP_GMUL    = 2'b10,
    OP_GSUM2   = 2'b11
  } sgOp_e;

  typedef struct packed {
    logic loadScatter;
    logic loadSum;
    logic loadMulPair;
    logic loadMulFinal;
  } sgStrobe_t;
endpackage

// File: rtl/sgCtrl.sv
module sgCtrl
  import sgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output sgStrobe_t  strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_MULWAIT, ST_HOLD} ctrlState_e;

  ctrlState_e state, stateNext;
  logic accept;
  logic isMul;

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_HOLD);
  assign accept   = inValid && inReady;
  assign isMul    = (opSel == OP_GMUL);

  always_comb begin
    strobe = '0;
    if (accept) begin
      case (opSel)
        OP_SCATTER: strobe.loadScatter = 1'b1;
        OP_GMUL:    strobe.loadMulPair = 1'b1;
        default:    strobe.loadSum     = 1'b1;
      endcase
    end
    if (state == ST_MULWAIT) strobe.loadMulFinal = 1'b1;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (accept) stateNext = isMul ? ST_MULWAIT : ST_HOLD;
      ST_MULWAIT: stateNext = ST_HOLD;
      ST_HOLD:    if (outReady) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R4
  single_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !isMul) |=> outValid);

  // R6
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isMul) |=> (!outValid ##1 outValid));

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (inReady && !outValid));
endmodule

// File: rtl/sgDatapath.sv
module sgDatapath
  import sgPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  sgStrobe_t             strobe,
  input  logic [SG_FCODE_W-1:0] fieldCode,
  input  logic [SG_DATA_W-1:0]  srcWord,
  input  logic [SG_DATA_W-1:0]  elem0,
  input  logic [SG_DATA_W-1:0]  elem1,
  input  logic [SG_DATA_W-1:0]  elem2,
  input  logic [SG_DATA_W-1:0]  elem3,
  output logic [SG_DATA_W-1:0]  res0,
  output logic [SG_DATA_W-1:0]  res1,
  output logic [SG_DATA_W-1:0]  res2,
  output logic [SG_DATA_W-1:0]  res3
);
  logic [SG_FW_W-1:0]   fieldW;
  logic [SG_DATA_W-1:0] fieldMask;
  logic [SG_DATA_W-1:0] scatVal [SG_LANES];
  logic [SG_DATA_W-1:0] resReg  [SG_LANES];
  logic [SG_DATA_W-1:0] sumVal;
  logic [SG_DATA_W-1:0] prodA, prodB;
  logic                 anyLoad;

  assign fieldW    = {1'b0, fieldCode} + SG_FW_W'(1);
  assign fieldMask = (SG_DATA_W'(1) << fieldW) - SG_DATA_W'(1);
  assign sumVal    = elem0 + elem1 + elem2 + elem3;
  assign anyLoad   = strobe.loadScatter | strobe.loadSum | strobe.loadMulFinal;

  for (genvar g = 0; g < SG_LANES; g++) begin : gLane
    logic [SG_SH_W-1:0] shAmt;
    assign shAmt = SG_SH_W'(g) * SG_SH_W'(fieldW);
    assign scatVal[g] = (shAmt >= SG_SH_W'(SG_DATA_W)) ? '0
                        : ((srcWord >> shAmt) & fieldMask);

    // R2
    lane_width_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadScatter |=> ((resReg[g] >> SG_MAXFW) == '0));

    // R9
    lane_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !anyLoad |=> $stable(resReg[g]));

    if (g > 0) begin : gUpper
      // R5
      gather_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.loadSum || strobe.loadMulFinal) |=> (resReg[g] == '0));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodA <= '0;
      prodB <= '0;
    end else if (strobe.loadMulPair) begin
      prodA <= elem0 * elem1;
      prodB <= elem2 * elem3;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SG_LANES; i++) resReg[i] <= '0;
    end else if (strobe.loadScatter) begin
      for (int i = 0; i < SG_LANES; i++) resReg[i] <= scatVal[i];
    end else if (strobe.loadSum || strobe.loadMulFinal) begin
      resReg[0] <= strobe.loadSum ? sumVal : (prodA * prodB);
      for (int i = 1; i < SG_LANES; i++) resReg[i] <= '0;
    end
  end

  assign res0 = resReg[0];
  assign res1 = resReg[1];
  assign res2 = resReg[2];
  assign res3 = resReg[3];
endmodule

// File: rtl/fieldScatterGather.sv
module fieldScatterGather
  import sgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [1:0]  opSel,
  input  logic [2:0]  fieldCode,
  input  logic [31:0] srcWord,
  input  logic [31:0] elem0,
  input  logic [31:0] elem1,
  input  logic [31:0] elem2,
  input  logic [31:0] elem3,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] res0,
  output logic [31:0] res1,
  output logic [31:0] res2,
  output logic [31:0] res3
);
  sgStrobe_t strobe;

  sgCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  sgDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fieldCode (fieldCode),
    .srcWord   (srcWord),
    .elem0     (elem0),
    .elem1     (elem1),
    .elem2     (elem2),
    .elem3     (elem3),
    .res0      (res0),
    .res1      (res1),
    .res2      (res2),
    .res3      (res3)
  );
endmodule

// File: tb/sim_fieldScatterGather.sv
module sim_fieldScatterGather;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  opSel = 2'b00;
  logic [2:0]  fieldCode = 3'd0;
  logic [31:0] srcWord = '0;
  logic [31:0] elem0 = '0, elem1 = '0, elem2 = '0, elem3 = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] res0, res1, res2, res3;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fieldScatterGather u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opSel(opSel), .fieldCode(fieldCode), .srcWord(srcWord),
    .elem0(elem0), .elem1(elem1), .elem2(elem2), .elem3(elem3),
    .outValid(outValid), .outReady(outReady),
    .res0(res0), .res1(res1), .res2(res2), .res3(res3)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expLane(int lane, logic [1:0] op, logic [2:0] code,
      logic [31:0] src, logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d);
    int w;
    int sh;
    logic [63:0] full;
    if (op == 2'b00) begin
      w  = int'(code) + 1;
      sh = lane * w;
      if (sh >= 32) return '0;
      full = {32'd0, src} >> sh;
      return full[31:0] & ((32'd1 << w) - 32'd1);
    end
    if (lane != 0) return '0;
    if (op == 2'b10) return a * b * c * d;
    return a + b + c + d;
  endfunction

  task automatic scramble();
    srcWord = $urandom; elem0 = $urandom; elem1 = $urandom;
    elem2 = $urandom; elem3 = $urandom; fieldCode = 3'($urandom);
  endtask

  task automatic runOp(logic [1:0] op, logic [2:0] code, logic [31:0] src,
      logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d,
      int holdCyc, string req);
    logic [31:0] e [4];
    for (int i = 0; i < 4; i++) e[i] = expLane(i, op, code, src, a, b, c, d);
    @(negedge clk);
    opSel = op; fieldCode = code; srcWord = src;
    elem0 = a; elem1 = b; elem2 = c; elem3 = d;
    inValid = 1'b1;
    chk("R8 idle inReady", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    scramble();
    if (op == 2'b10) begin
      chk("R6 early outValid", 32'(outValid), 32'd0);
      @(negedge clk);
      chk("R6 outValid", 32'(outValid), 32'd1);
    end else begin
      chk("R4 outValid", 32'(outValid), 32'd1);
    end
    chk({req, " res0"}, res0, e[0]);
    chk({req, " res1"}, res1, e[1]);
    chk({req, " res2"}, res2, e[2]);
    chk({req, " res3"}, res3, e[3]);
    for (int k = 0; k < holdCyc; k++) begin
      inValid = 1'b1;
      opSel = 2'($urandom);
      scramble();
      @(negedge clk);
      chk("R8 held outValid", 32'(outValid), 32'd1);
      chk("R8 busy inReady", 32'(inReady), 32'd0);
      chk("R9 held res0", res0, e[0]);
      chk("R9 held res3", res3, e[3]);
    end
    inValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk("R8 released outValid", 32'(outValid), 32'd0);
    chk("R8 released inReady", 32'(inReady), 32'd1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R1: reset state while reset is applied and after release
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R1 inReady", 32'(inReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 res0", res0, 32'd0);
    chk("R1 res1", res1, 32'd0);
    chk("R1 res2", res2, 32'd0);
    chk("R1 res3", res3, 32'd0);

    // R3: byte split of a packed pixel
    runOp(2'b00, 3'd7, 32'hAABBCCDD, 32'h1, 32'h2, 32'h3, 32'h4, 0, "R3 bytes");
    // R2: narrowest and intermediate field widths
    runOp(2'b00, 3'd0, 32'h0000000A, '0, '0, '0, '0, 1, "R2 width1");
    runOp(2'b00, 3'd3, 32'hFFFF1234, '0, '0, '0, '0, 0, "R2 width4");
    runOp(2'b00, 3'd4, 32'hFFFFFFFF, '0, '0, '0, '0, 2, "R2 width5");
    // R10: scatter with different elements gives the same lanes
    runOp(2'b00, 3'd5, 32'h89ABCDEF, 32'hDEADBEEF, 32'h1, 32'h2, 32'h3, 0, "R10 scatter");
    // R5: sum with wraparound
    runOp(2'b01, 3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h2, 32'h3, 32'h4, 0, "R5 sum wrap");
    // R11: packing of non-overlapping channels equals OR
    runOp(2'b01, 3'd0, '0, 32'h00000012, 32'h00003400, 32'h00560000, 32'h78000000, 0, "R11 pack");
    @(negedge clk);
    chk("R11 pack equals OR", 32'h78563412, 32'h12 | 32'h3400 | 32'h560000 | 32'h78000000);
    // R6: product corner cases
    runOp(2'b10, 3'd7, '0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, "R6 ones");
    runOp(2'b10, 3'd7, '0, 32'h00010000, 32'h00000001, 32'h00010000, 32'h00000001, 0, "R6 wrap zero");
    runOp(2'b10, 3'd1, 32'h5, 32'd3, 32'd5, 32'd7, 32'd11, 2, "R6 small");
    // R7: alternate sum code
    runOp(2'b11, 3'd6, 32'h1234, 32'd100, 32'd200, 32'd300, 32'd400, 1, "R7 alt sum");

    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      op = 2'($urandom);
      runOp(op, 3'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom,
            int'($urandom % 3),
            (op == 2'b00) ? "R2 random scatter" :
            (op == 2'b10) ? "R6 random product" :
            (op == 2'b11) ? "R7 random alt" : "R5 random sum");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule